// File: doc/BRIEF.md
# Masked Pipelined Adder Tree

This block adds up to thirty narrow input terms into a single sum through a five-level binary tree of adders. The result of each level is one bit wider than that level's inputs, and pipeline registers sit between the levels. The thirty lanes are padded with two zero lanes to give a full tree of thirty-two. The first two levels each take one register stage. The last three levels each take two register stages: the add, then a hold register. An input sample therefore reaches the outputs eight clock edges after it is captured, and a valid flag travels alongside it.

Masking happens at two points. Each input lane can be forced to zero before the first adders. Separately, each of the eight operands entering the third level can be forced to zero; each of those operands carries a group of four consecutive inputs. Mask values are written by a host into shadow registers. They take effect only when a frame-boundary strobe copies them into the active set, so no sum mixes two mask settings. Each instance keeps its own mask set, so incoherent and phased combiners each get an independent set.

A parameter picks unsigned addition (power terms) or two's-complement addition (real and imaginary terms). The two operands of the final level are brought out as sub-group partial sums. They are delayed so that they line up with the full sum.

Top module: `masked_adder_tree`

## Requirements
- R1: After reset, out_valid, sum_out, part_a and part_b are zero. Both active masks are all ones (every input included).
- R2: A sample captured with in_valid high at clock edge k appears on sum_out at edge k+8. sum_out is the sum of the included input lanes. Lane i is in_data[5i+4:5i].
- R3: out_valid at edge k+8 equals in_valid at edge k.
- R4: Active input-mask bit i at 0 removes input lane i from every sum. This mask is written with cfg_we=1 and cfg_sel=0, and bit i of cfg_data maps to lane i.
- R5: Active third-level mask bit j at 0 removes inputs 4j to 4j+3 from every sum. This mask is written with cfg_we=1 and cfg_sel=1, using cfg_data[7:0].
- R6: With SIGNED=0, lanes and sums are unsigned. With SIGNED=1, each lane is a 5-bit two's-complement value and sum_out is the exact two's-complement sum.
- R7: part_a is the masked sum of lanes 0 to 15 and part_b is the masked sum of lanes 16 to 29. Both are aligned with sum_out, so sum_out = part_a + part_b every cycle.
- R8: A mask write changes only the shadow copy. The active masks change only at an edge where mask_apply is high, and then take the shadow value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 150 | Thirty 5-bit lanes, lane 0 in the low bits |
| cfg_we | input | 1 | Mask shadow write enable |
| cfg_sel | input | 1 | 0: input mask, 1: third-level mask |
| cfg_data | input | 30 | Mask write value |
| mask_apply | input | 1 | Frame-boundary strobe: copy shadow masks to active |
| out_valid | output | 1 | Output strobe aligned with the sums |
| sum_out | output | 10 | Full sum |
| part_a | output | 9 | Partial sum of lanes 0 to 15 |
| part_b | output | 9 | Partial sum of lanes 16 to 29 |

## Verification
The assertions check three things on every cycle: the eight-cycle travel of the valid flag, the equality of the full sum with the two partial sums in the selected arithmetic, and the rule that active masks move only on the apply strobe and then copy the shadow. Only the bench scenarios can show that the sums themselves are correct. That covers random and extreme lane values in both arithmetic modes, single-lane and group masking, and staged mask writes that must stay inert until applied.

// File: rtl/adder_tree_pkg.sv
package adder_tree_pkg;
    localparam int TREE_LANES  = 32;
    localparam int TREE_LEVELS = 5;
    localparam int GROUP_OPS   = TREE_LANES >> 2;
    localparam int LATENCY     = 8;
    localparam bit SEL_IN_MASK = 1'b0;
    localparam bit SEL_L3_MASK = 1'b1;
endpackage

// File: rtl/mask_regs.sv
module mask_regs #(
    parameter int N_IN = 30,
    parameter int N_L3 = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [N_IN-1:0] cfg_data,
    input  logic            mask_apply,
    output logic [N_IN-1:0] act_in,
    output logic [N_L3-1:0] act_l3
);
    import adder_tree_pkg::*;

    typedef struct packed {
        logic [N_IN-1:0] sh_in;
        logic [N_L3-1:0] sh_l3;
        logic [N_IN-1:0] ac_in;
        logic [N_L3-1:0] ac_l3;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (cfg_sel == SEL_IN_MASK) st_d.sh_in = cfg_data;
            else                        st_d.sh_l3 = cfg_data[N_L3-1:0];
        end
        if (mask_apply) begin
            st_d.ac_in = st_q.sh_in;
            st_d.ac_l3 = st_q.sh_l3;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign act_in = st_q.ac_in;
    assign act_l3 = st_q.ac_l3;

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_apply |=> ($stable(act_in) && $stable(act_l3)));

    // R8
    mask_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_apply |=> (act_in == $past(st_q.sh_in) && act_l3 == $past(st_q.sh_l3)));
endmodule

// File: rtl/tree_level.sv
module tree_level #(
    parameter int PAIRS  = 16,
    parameter int IW     = 5,
    parameter bit SIGNED = 1'b0,
    parameter int DEPTH  = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2*PAIRS*IW-1:0]       opnd,
    output logic [PAIRS*(IW+1)-1:0]     sum_o
);
    localparam int OW = IW + 1;
    localparam int VW = PAIRS * OW;

    function automatic logic [OW-1:0] widen(input logic [IW-1:0] v);
        return {(SIGNED ? v[IW-1] : 1'b0), v};
    endfunction

    logic [VW-1:0] pipe_d [DEPTH];
    logic [VW-1:0] pipe_q [DEPTH];

    always_comb begin
        pipe_d[0] = '0;
        for (int p = 0; p < PAIRS; p++) begin
            pipe_d[0][p*OW +: OW] = widen(opnd[2*p*IW +: IW])
                                  + widen(opnd[(2*p+1)*IW +: IW]);
        end
        for (int s = 1; s < DEPTH; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) pipe_q[s] <= '0;
        end else begin
            for (int s = 0; s < DEPTH; s++) pipe_q[s] <= pipe_d[s];
        end
    end

    assign sum_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/delay_line.sv
module delay_line #(
    parameter int W     = 1,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] dl_d [DEPTH];
    logic [W-1:0] dl_q [DEPTH];

    always_comb begin
        dl_d[0] = din;
        for (int s = 1; s < DEPTH; s++) dl_d[s] = dl_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) dl_q[s] <= '0;
        end else begin
            for (int s = 0; s < DEPTH; s++) dl_q[s] <= dl_d[s];
        end
    end

    assign dout = dl_q[DEPTH-1];
endmodule

// File: rtl/masked_adder_tree.sv
module masked_adder_tree #(
    parameter int N_IN   = 30,
    parameter int IN_W   = 5,
    parameter bit SIGNED = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [N_IN*IN_W-1:0] in_data,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [N_IN-1:0]      cfg_data,
    input  logic                 mask_apply,
    output logic                 out_valid,
    output logic [IN_W+4:0]      sum_out,
    output logic [IN_W+3:0]      part_a,
    output logic [IN_W+3:0]      part_b
);
    import adder_tree_pkg::*;

    localparam int W1     = IN_W + 1;
    localparam int W2     = IN_W + 2;
    localparam int W3     = IN_W + 3;
    localparam int W4     = IN_W + 4;
    localparam int SUM_W  = IN_W + TREE_LEVELS;
    localparam int TAP_DL = 2;

    logic [N_IN-1:0]          act_in;
    logic [GROUP_OPS-1:0]     act_l3;
    logic [TREE_LANES*IN_W-1:0] lvl0;
    logic [16*W1-1:0]         lvl1;
    logic [8*W2-1:0]          lvl2;
    logic [8*W2-1:0]          lvl2_m;
    logic [4*W3-1:0]          lvl3;
    logic [2*W4-1:0]          lvl4;
    logic [2*W4-1:0]          taps;

    mask_regs #(.N_IN(N_IN), .N_L3(GROUP_OPS)) u_masks (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .mask_apply(mask_apply),
        .act_in(act_in), .act_l3(act_l3)
    );

    generate
        for (genvar i = 0; i < TREE_LANES; i++) begin : g_lane
            if (i < N_IN) begin : g_live
                assign lvl0[i*IN_W +: IN_W] = act_in[i] ? in_data[i*IN_W +: IN_W] : '0;
            end else begin : g_pad
                assign lvl0[i*IN_W +: IN_W] = '0;
            end
        end
        for (genvar j = 0; j < GROUP_OPS; j++) begin : g_grp
            assign lvl2_m[j*W2 +: W2] = act_l3[j] ? lvl2[j*W2 +: W2] : '0;
        end
    endgenerate

    tree_level #(.PAIRS(16), .IW(IN_W), .SIGNED(SIGNED), .DEPTH(1)) u_l1 (
        .clk(clk), .rst_n(rst_n), .opnd(lvl0), .sum_o(lvl1));
    tree_level #(.PAIRS(8), .IW(W1), .SIGNED(SIGNED), .DEPTH(1)) u_l2 (
        .clk(clk), .rst_n(rst_n), .opnd(lvl1), .sum_o(lvl2));
    tree_level #(.PAIRS(4), .IW(W2), .SIGNED(SIGNED), .DEPTH(2)) u_l3 (
        .clk(clk), .rst_n(rst_n), .opnd(lvl2_m), .sum_o(lvl3));
    tree_level #(.PAIRS(2), .IW(W3), .SIGNED(SIGNED), .DEPTH(2)) u_l4 (
        .clk(clk), .rst_n(rst_n), .opnd(lvl3), .sum_o(lvl4));
    tree_level #(.PAIRS(1), .IW(W4), .SIGNED(SIGNED), .DEPTH(2)) u_l5 (
        .clk(clk), .rst_n(rst_n), .opnd(lvl4), .sum_o(sum_out));

    delay_line #(.W(2*W4), .DEPTH(TAP_DL)) u_taps (
        .clk(clk), .rst_n(rst_n), .din(lvl4), .dout(taps));
    delay_line #(.W(1), .DEPTH(LATENCY)) u_vld (
        .clk(clk), .rst_n(rst_n), .din(in_valid), .dout(out_valid));

    assign part_a = taps[0 +: W4];
    assign part_b = taps[W4 +: W4];

    // R3
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##8 out_valid);

    // R3
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##8 !out_valid);

    generate
        if (SIGNED) begin : g_sgn_chk
            // R7
            part_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $signed(sum_out) == ($signed({part_a[W4-1], part_a}) + $signed({part_b[W4-1], part_b})));
        end else begin : g_uns_chk
            // R7
            part_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sum_out == (SUM_W'({1'b0, part_a}) + SUM_W'({1'b0, part_b})));
        end
    endgenerate
endmodule

// File: tb/sim_masked_adder_tree.sv
`timescale 1ns/1ps
module sim_masked_adder_tree;
    localparam int N  = 30;
    localparam int IW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [N*IW-1:0] in_data = '0;
    logic cfg_we = 1'b0;
    logic cfg_sel = 1'b0;
    logic [N-1:0] cfg_data = '0;
    logic mask_apply = 1'b0;

    logic       u_vld, s_vld;
    logic [9:0] u_sum, s_sum;
    logic [8:0] u_pa, u_pb, s_pa, s_pb;

    always #2.5 clk = ~clk;

    masked_adder_tree #(.N_IN(N), .IN_W(IW), .SIGNED(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .mask_apply(mask_apply),
        .out_valid(u_vld), .sum_out(u_sum), .part_a(u_pa), .part_b(u_pb));

    masked_adder_tree #(.N_IN(N), .IN_W(IW), .SIGNED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .mask_apply(mask_apply),
        .out_valid(s_vld), .sum_out(s_sum), .part_a(s_pa), .part_b(s_pb));

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [N-1:0] m_sh_in = '1, m_ac_in = '1;
    logic [7:0]   m_sh_l3 = '1, m_ac_l3 = '1;

    logic       e_v   [8];
    logic [9:0] e_us  [8];
    logic [9:0] e_ss  [8];
    logic [8:0] e_ua  [8];
    logic [8:0] e_ub  [8];
    logic [8:0] e_sa  [8];
    logic [8:0] e_sb  [8];

    function automatic int grp_sum(input logic [N*IW-1:0] d, input logic [N-1:0] m1,
                                   input logic [7:0] m3, input bit sgn, input int lo, input int hi);
        int s = 0;
        for (int i = lo; i < hi; i++) begin
            logic [IW-1:0] v = d[i*IW +: IW];
            if (m1[i] && m3[i/4]) s += sgn ? int'($signed(v)) : int'(v);
        end
        return s;
    endfunction

    task automatic chk(input logic [9:0] got, input logic [9:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, what, got, exp);
        end
    endtask

    task automatic tick(input logic v, input logic [N*IW-1:0] d);
        int ua, ub, sa, sb;
        @(negedge clk);
        chk({9'b0, u_vld}, {9'b0, e_v[7]}, "R3 out_valid u0");
        chk({9'b0, s_vld}, {9'b0, e_v[7]}, "R3 out_valid u1");
        if (e_v[7]) begin
            chk(u_sum, e_us[7], "R2 sum u0");
            chk(s_sum, e_ss[7], "R6 signed sum u1");
            chk({1'b0, u_pa}, {1'b0, e_ua[7]}, "R7 part_a u0");
            chk({1'b0, u_pb}, {1'b0, e_ub[7]}, "R7 part_b u0");
            chk({1'b0, s_pa}, {1'b0, e_sa[7]}, "R7 part_a u1");
            chk({1'b0, s_pb}, {1'b0, e_sb[7]}, "R7 part_b u1");
        end
        for (int k = 7; k > 0; k--) begin
            e_v[k] = e_v[k-1]; e_us[k] = e_us[k-1]; e_ss[k] = e_ss[k-1];
            e_ua[k] = e_ua[k-1]; e_ub[k] = e_ub[k-1]; e_sa[k] = e_sa[k-1]; e_sb[k] = e_sb[k-1];
        end
        ua = grp_sum(d, m_ac_in, m_ac_l3, 1'b0, 0, 16);
        ub = grp_sum(d, m_ac_in, m_ac_l3, 1'b0, 16, N);
        sa = grp_sum(d, m_ac_in, m_ac_l3, 1'b1, 0, 16);
        sb = grp_sum(d, m_ac_in, m_ac_l3, 1'b1, 16, N);
        e_v[0] = v;
        e_us[0] = 10'(ua + ub);
        e_ss[0] = 10'(sa + sb);
        e_ua[0] = 9'(ua); e_ub[0] = 9'(ub);
        e_sa[0] = 9'(sa); e_sb[0] = 9'(sb);
        in_valid = v;
        in_data = d;
        cfg_we = 1'b0;
        mask_apply = 1'b0;
    endtask

    function automatic logic [N*IW-1:0] rnd_vec();
        logic [N*IW-1:0] d;
        for (int i = 0; i < N; i++) d[i*IW +: IW] = IW'($urandom_range(0, 31));
        return d;
    endfunction

    function automatic logic [N*IW-1:0] fill(input logic [IW-1:0] v);
        logic [N*IW-1:0] d;
        for (int i = 0; i < N; i++) d[i*IW +: IW] = v;
        return d;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0);
    endtask

    task automatic cfg_write(input logic sel, input logic [N-1:0] val);
        tick(1'b0, '0);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
        if (sel) m_sh_l3 = val[7:0]; else m_sh_in = val;
    endtask

    task automatic apply_masks();
        idle(9);
        tick(1'b0, '0);
        mask_apply = 1'b1;
        m_ac_in = m_sh_in;
        m_ac_l3 = m_sh_l3;
    endtask

    task automatic burst(input int n, input string tag);
        cur_req = tag;
        for (int i = 0; i < n; i++) tick(1'b1, rnd_vec());
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) begin
            e_v[k] = 0; e_us[k] = 0; e_ss[k] = 0; e_ua[k] = 0; e_ub[k] = 0; e_sa[k] = 0; e_sb[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk({9'b0, u_vld}, 10'd0, "R1 reset out_valid");
        chk(u_sum, 10'd0, "R1 reset sum");
        chk({1'b0, u_pa}, 10'd0, "R1 reset part_a");
        chk({1'b0, s_pb}, 10'd0, "R1 reset part_b");
        // R1: masks reset to all ones, so first burst sums all lanes
        burst(20, "R1/R2 reset masks and random sums");

        // R2/R6 directed extremes
        cur_req = "R2/R6 extremes";
        tick(1'b1, fill(5'h1F));
        tick(1'b1, fill(5'h10));
        tick(1'b1, fill(5'h0F));
        tick(1'b1, fill(5'h00));
        tick(1'b1, {5'h1F, {(N-1)*IW{1'b0}}});

        // R3 irregular valid pattern
        cur_req = "R3 gaps";
        for (int i = 0; i < 40; i++) tick(1'(($urandom_range(0, 2)) != 0), rnd_vec());
        idle(10);

        // R8 staged write has no effect until applied
        cfg_write(1'b0, 30'h2AAA_5555);
        cfg_write(1'b1, 30'h0000_005A);
        burst(12, "R8 staged writes inert");
        apply_masks();
        burst(25, "R4/R5 applied masks");
        tick(1'b1, fill(5'h10));
        tick(1'b1, fill(5'h1F));

        // R4 single lane enabled
        cfg_write(1'b0, 30'h2000_0000);
        cfg_write(1'b1, 30'h0000_00FF);
        apply_masks();
        cur_req = "R4 single lane 29";
        tick(1'b1, fill(5'h13));
        tick(1'b1, fill(5'h0B));
        burst(6, "R4 single lane random");

        // R5 group masking with full input mask
        cfg_write(1'b0, '1);
        cfg_write(1'b1, 30'h0000_0081);
        apply_masks();
        burst(15, "R5 group mask");
        cfg_write(1'b1, 30'h0000_000F);
        apply_masks();
        burst(15, "R7 only group a");
        cfg_write(1'b1, 30'h0000_00F0);
        apply_masks();
        cur_req = "R7 only group b";
        tick(1'b1, fill(5'h10));
        burst(10, "R7 only group b random");

        // all masked out
        cfg_write(1'b0, '0);
        apply_masks();
        burst(6, "R4 all masked");
        idle(10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule